// File: doc/BRIEF.md
# TLB Replacement Pointer Unit

This block holds the replacement state for a small address-translation cache pair. For a four-way instruction-side TLB it keeps a 6-bit pseudo-LRU field built from pairwise-order bits. Every hit or fill on a way rewrites that way's bits. The field is decoded at all times into the way that should be evicted next. A field value that no decode rule accepts is flagged and falls back to way 0.

For the 64-entry unified TLB it keeps a 6-bit replacement counter that steps on every unified access. The counter returns to 0 after it passes a programmable bound, or after 63 when the bound is 0. A single register write port loads the LRU field, the counter and the bound together. A write takes priority over a hit or an access in the same cycle. The TLB arrays themselves live elsewhere.

Top module: `tlb_repl_unit`

## Requirements
- R1: After reset the LRU field, the counter and the bound are 0, the illegal flag is 0 and the victim is way 3.
- R2: A hit on way 0 clears field bits 5,4,3. A hit on way 1 sets bit 5 and clears bits 2,1. A hit on way 2 sets bits 4,2 and clears bit 0. A hit on way 3 sets bits 3,1,0. All other bits are unchanged, and the new field is visible the cycle after the hit.
- R3: The victim is chosen by the first matching rule in this order: way 0 when bits 5,4,3 are all 1; way 1 when bit 5 is 0 and bits 2,1 are 1; way 2 when bits 4,2 are 0 and bit 0 is 1; way 3 when bits 3,1,0 are all 0.
- R4: A field that matches no rule selects way 0 and raises the illegal flag. The flag stays set until reset, even after the field becomes legal.
- R5: The counter rises by 1 on each cycle with the unified access strobe and holds otherwise.
- R6: With a nonzero bound, an access that would take the counter above the bound loads 0 instead.
- R7: With bound 0, the counter goes from 63 to 0.
- R8: A register write loads the LRU field, the counter and the bound, and it wins over a hit or an access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Instruction TLB hit or fill strobe |
| hit_way_i | input | 2 | Way that was hit or filled |
| uacc_i | input | 1 | Unified TLB access strobe |
| wr_i | input | 1 | Register write strobe |
| wr_lru_i | input | 6 | LRU field write data |
| wr_cnt_i | input | 6 | Counter write data |
| wr_bound_i | input | 6 | Bound write data |
| victim_o | output | 2 | Way to replace next |
| cnt_o | output | 6 | Replacement counter |
| illegal_o | output | 1 | Sticky illegal-field flag |

## Verification
A register write can land in the same cycle as an instruction-side hit and a unified access. The bench drives all three strobes in one cycle, with write data that differs from what the hit and the step would produce. It then expects the written counter and the victim decoded from the written field, not the stepped or hit-updated values. On the next access alone it expects the counter to step from the written value under the written bound.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int LRU_W = 6;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [LRU_W-1:0] lru_t;

  // bits that decide way w
  function automatic lru_t way_care(input int w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b100110;
      2:       return 6'b010101;
      default: return 6'b001011;
    endcase
  endfunction

  // value of the cared bits when way w is the victim
  function automatic lru_t way_want(input int w);
    case (w)
      0:       return 6'b111000;
      1:       return 6'b000110;
      2:       return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/itlb_plru_ctl.sv
module itlb_plru_ctl
  import tlb_repl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             wr_i,
  input  lru_t             wr_lru_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             illegal_o
);
  lru_t            lru_q;
  logic            illegal_q;
  logic [WAYS-1:0] rule_match;
  logic            lru_bad;
  lru_t            hit_care, hit_val;

  always_comb begin
    hit_care = way_care(int'(hit_way_i));
    hit_val  = hit_care & ~way_want(int'(hit_way_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lru_q <= '0;
    else if (wr_i)  lru_q <= wr_lru_i;
    else if (hit_i) lru_q <= (lru_q & ~hit_care) | hit_val;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rule
    assign rule_match[w] = (lru_q & way_care(w)) == way_want(w);
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && rule_match[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end

  assign lru_bad = ~|rule_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= illegal_q | lru_bad;
  end

  assign illegal_o = illegal_q | lru_bad;

  p_hit_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !wr_i) |=> ((lru_q & way_care(int'($past(hit_way_i))))
                          == (way_care(int'($past(hit_way_i)))
                              & ~way_want(int'($past(hit_way_i))))));
  p_hit_keeps_rest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !wr_i) |=> ((lru_q & ~way_care(int'($past(hit_way_i))))
                          == ($past(lru_q) & ~way_care(int'($past(hit_way_i))))));
  p_illegal_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  p_illegal_way0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lru_bad |-> (victim_o == '0 && illegal_o));
  p_write_lru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> lru_q == $past(wr_lru_i));
endmodule

// File: rtl/utlb_rand_ctr.sv
module utlb_rand_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uacc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] wr_bound_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, bound_q;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = ((bound_q != '0) && (cnt_inc > {1'b0, bound_q})) || (cnt_inc > CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bound_q <= '0;
    end else if (wr_i) begin
      cnt_q   <= wr_cnt_i;
      bound_q <= wr_bound_i;
    end else if (uacc_i) begin
      cnt_q   <= wrap ? '0 : cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uacc_i && !wr_i) |=> $stable(cnt_q));
  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uacc_i && !wr_i && cnt_q != {CNT_W{1'b1}} && (bound_q == '0 || cnt_q < bound_q))
    |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uacc_i && !wr_i && bound_q != '0 && cnt_q >= bound_q) |=> cnt_q == '0);
  p_wrap_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uacc_i && !wr_i && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == '0);
  p_write_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wr_cnt_i) && bound_q == $past(wr_bound_i)));
endmodule

// File: rtl/tlb_repl_unit.sv
module tlb_repl_unit
  import tlb_repl_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             uacc_i,
  input  logic             wr_i,
  input  logic [LRU_W-1:0] wr_lru_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] wr_bound_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             illegal_o
);
  itlb_plru_ctl u_plru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit_i),
    .hit_way_i (hit_way_i),
    .wr_i      (wr_i),
    .wr_lru_i  (wr_lru_i),
    .victim_o  (victim_o),
    .illegal_o (illegal_o)
  );

  utlb_rand_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .uacc_i     (uacc_i),
    .wr_i       (wr_i),
    .wr_cnt_i   (wr_cnt_i),
    .wr_bound_i (wr_bound_i),
    .cnt_o      (cnt_o)
  );

  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cnt_o == '0 && !illegal_o && victim_o == WAY_W'(3)));
endmodule

// File: tb/tlb_repl_unit_tb.sv
`timescale 1ns/1ps
module tlb_repl_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hit_i = 1'b0;
  logic [1:0] hit_way_i = '0;
  logic       uacc_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [5:0] wr_lru_i = '0;
  logic [5:0] wr_cnt_i = '0;
  logic [5:0] wr_bound_i = '0;
  logic [1:0] victim_o;
  logic [5:0] cnt_o;
  logic       illegal_o;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_lru;

  always #2.5 clk_i = ~clk_i;

  tlb_repl_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .hit_way_i(hit_way_i),
    .uacc_i(uacc_i), .wr_i(wr_i), .wr_lru_i(wr_lru_i), .wr_cnt_i(wr_cnt_i),
    .wr_bound_i(wr_bound_i), .victim_o(victim_o), .cnt_o(cnt_o), .illegal_o(illegal_o)
  );

  function automatic logic [5:0] upd(input logic [5:0] f, input logic [1:0] w);
    logic [5:0] r;
    r = f;
    case (w)
      2'd0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
      2'd1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
      2'd2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
      default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
    endcase
    return r;
  endfunction

  function automatic logic [2:0] pick(input logic [5:0] f);
    if (f[5] && f[4] && f[3]) return 3'd0;
    if (!f[5] && f[2] && f[1]) return 3'd1;
    if (!f[4] && !f[2] && f[0]) return 3'd2;
    if (!f[3] && !f[1] && !f[0]) return 3'd3;
    return 3'd4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    hit_i = 0; uacc_i = 0; wr_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_write(input logic [5:0] l, input logic [5:0] c, input logic [5:0] b);
    wr_i = 1; wr_lru_i = l; wr_cnt_i = c; wr_bound_i = b;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 victim", victim_o, 3);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 illegal", illegal_o, 0);
  endtask

  task automatic t_lru_walk();
    logic [1:0] seq [8] = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd2, 2'd2, 2'd1, 2'd3};
    m_lru = '0;
    foreach (seq[i]) begin
      hit_i = 1; hit_way_i = seq[i];
      cyc();
      m_lru = upd(m_lru, seq[i]);
      chk("R2 victim after hit", victim_o, (pick(m_lru) == 3'd4) ? 0 : int'(pick(m_lru)));
    end
    chk("R2 cnt untouched by hit", cnt_o, 0);
  endtask

  task automatic t_priority();
    logic [5:0] pats [6] = '{6'b111000, 6'b000110, 6'b000001, 6'b000000, 6'b110100, 6'b011110};
    foreach (pats[i]) begin
      do_write(pats[i], 6'd0, 6'd0);
      chk("R3 decode", victim_o, int'(pick(pats[i])));
      chk("R3 legal", illegal_o, 0);
    end
  endtask

  task automatic t_illegal();
    do_write(6'b101010, 6'd0, 6'd0);
    chk("R4 way0", victim_o, 0);
    chk("R4 flag", illegal_o, 1);
    do_write(6'b000000, 6'd0, 6'd0);
    chk("R4 legal victim", victim_o, 3);
    chk("R4 sticky", illegal_o, 1);
    cyc();
    chk("R4 still sticky", illegal_o, 1);
  endtask

  task automatic t_count();
    do_write(6'b000000, 6'd7, 6'd0);
    chk("R8 cnt load", cnt_o, 7);
    uacc_i = 1; cyc();
    chk("R5 step", cnt_o, 8);
    cyc(); cyc();
    chk("R5 hold", cnt_o, 8);
    uacc_i = 1; cyc();
    uacc_i = 1; cyc();
    chk("R5 two steps", cnt_o, 10);
  endtask

  task automatic t_bound_wrap();
    int exp [4] = '{4, 5, 0, 1};
    do_write(6'b000000, 6'd3, 6'd5);
    foreach (exp[i]) begin
      uacc_i = 1; cyc();
      chk("R6 bounded", cnt_o, exp[i]);
    end
    do_write(6'b000000, 6'd9, 6'd5);
    uacc_i = 1; cyc();
    chk("R6 above bound", cnt_o, 0);
  endtask

  task automatic t_full_wrap();
    int exp [5] = '{61, 62, 63, 0, 1};
    do_write(6'b000000, 6'd60, 6'd0);
    foreach (exp[i]) begin
      uacc_i = 1; cyc();
      chk("R7 top wrap", cnt_o, exp[i]);
    end
  endtask

  task automatic t_collide();
    hit_i = 1; hit_way_i = 2'd0; uacc_i = 1;
    wr_i = 1; wr_lru_i = 6'b000110; wr_cnt_i = 6'd10; wr_bound_i = 6'd11;
    cyc();
    chk("R8 cnt wins", cnt_o, 10);
    chk("R8 lru wins", victim_o, 1);
    uacc_i = 1; cyc();
    chk("R8 step after", cnt_o, 11);
    uacc_i = 1; cyc();
    chk("R8 written bound", cnt_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_lru_walk();
    t_priority();
    t_count();
    t_bound_wrap();
    t_full_wrap();
    t_collide();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule